// File: doc/BRIEF.md
# Gated Timer/Counter Channel

This block is one timer/counter channel with a 16-bit count, held as a high byte and a low byte. It has two count sources. In tick mode it counts system clock cycles after a fixed prescaler has divided them down. In pin mode it counts falling edges on an external pin, which first passes through a synchronizer.

A run bit turns counting on. When gate mode is selected, an external gate pin must also be high for counting to happen. Software picks one of two count widths:

- **Wide mode** uses the full 16 bits.
- **Narrow mode** uses a 13-bit count, built from the five low bits of the low byte and the whole high byte.

When the active width rolls over from all ones to zero, a sticky overflow flag is set. Software can write either byte at any time, and it clears the flag with a pulse. All pins are plain control and status signals. No data stream crosses the block's edge, so the block has no valid/ready handshake and no back-pressure.

Top module: `gated_tick_counter`

## Requirements
- R1: After reset, count_lo and count_hi are 0x00, ovf_flag is 0, and the prescaler phase is zero.
- R2: In tick mode (src_sel = 0), the count advances once for every 12 clock cycles in which counting is enabled. The first advance comes on the 12th enabled cycle after reset. The prescaler phase holds while counting is disabled or src_sel = 1.
- R3: In pin mode (src_sel = 1), each falling edge of cnt_pin advances the count once. If cnt_pin goes low just before clock edge k, the count changes at edge k+2.
- R4: Pulses with one cycle low and one cycle high, the highest supported rate, are all counted.
- R5: Counting is enabled exactly when run_en = 1 and either gate_mode = 0 or gate_pin = 1. When counting is disabled and no byte write is made, the count does not change.
- R6: In wide mode (wide_mode = 1), the count {count_hi, count_lo} wraps from 0xFFFF to 0x0000, and that wrap sets ovf_flag.
- R7: In narrow mode (wide_mode = 0), the 13-bit value {count_hi, count_lo[4:0]} increments. Bits count_lo[7:5] are left unchanged. A wrap from 0x1FFF to zero sets ovf_flag.
- R8: ovf_flag stays set until flag_clr is pulsed. If a wrap and flag_clr fall in the same cycle, the flag stays set.
- R9: lo_wr_en or hi_wr_en loads that byte from its data input on the next edge. In a cycle with any byte write, neither byte advances. The tick-mode prescaler keeps running through such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_pin | input | 1 | External count input; falling edges are counted in pin mode |
| gate_pin | input | 1 | External gate input, used when gate_mode = 1 |
| run_en | input | 1 | Run bit |
| gate_mode | input | 1 | 1 = counting also requires gate_pin high |
| src_sel | input | 1 | 0 = prescaled clock ticks, 1 = falling edges on cnt_pin |
| wide_mode | input | 1 | 1 = 16-bit count, 0 = 13-bit count |
| lo_wr_en | input | 1 | Write strobe for the low byte |
| lo_wr_data | input | 8 | Low byte write value |
| hi_wr_en | input | 1 | Write strobe for the high byte |
| hi_wr_data | input | 8 | High byte write value |
| flag_clr | input | 1 | Clears ovf_flag |
| count_lo | output | 8 | Low byte of the count |
| count_hi | output | 8 | High byte of the count |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its default parameters: a divide-by-12 prescaler, two synchronizer stages, 8-bit bytes and a 5-bit narrow low field. With this configuration, all 32 combinations of run, gate mode, gate pin, source and width can be swept, each with an expected delta worked out in arithmetic. The narrow-mode wrap is run once for each of the eight patterns in the untouched low-byte bits. The prescaler phase is tracked as a running modulo-12 total, so runs whose length is not a multiple of 12 still have exact expectations.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {
    SRC_TICK = 1'b0,
    SRC_PIN  = 1'b1
  } src_e;
endpackage

// File: rtl/tmr_fall_detect.sv
module tmr_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q[0] <= pin_i;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];

  // R4
  fall_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = en_i;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase_q;

      assign tick_o = en_i && (phase_q == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     phase_q <= '0;
        else if (en_i)  phase_q <= tick_o ? '0 : phase_q + 1'b1;
      end

      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int BYTE_W    = 8,
  parameter int NARROW_LO = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              wide_i,
  input  logic              lo_wr_i,
  input  logic [BYTE_W-1:0] lo_data_i,
  input  logic              hi_wr_i,
  input  logic [BYTE_W-1:0] hi_data_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              wrap_o
);
  localparam int FW = 2 * BYTE_W;
  localparam int NW = BYTE_W + NARROW_LO;

  logic [BYTE_W-1:0] lo_q, hi_q;
  logic [FW-1:0]     full_val;
  logic [NW-1:0]     narrow_val;
  logic              any_wr, do_step;

  assign full_val   = {hi_q, lo_q};
  assign narrow_val = {hi_q, lo_q[NARROW_LO-1:0]};
  assign any_wr     = lo_wr_i | hi_wr_i;
  assign do_step    = step_i & ~any_wr;
  assign wrap_o     = do_step & (wide_i ? (&full_val) : (&narrow_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (any_wr) begin
      if (lo_wr_i) lo_q <= lo_data_i;
      if (hi_wr_i) hi_q <= hi_data_i;
    end else if (do_step) begin
      if (wide_i) {hi_q, lo_q} <= full_val + 1'b1;
      else        {hi_q, lo_q[NARROW_LO-1:0]} <= narrow_val + 1'b1;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  // R7
  narrow_top_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_i && !lo_wr_i) |=> $stable(lo_q[BYTE_W-1:NARROW_LO]));
  // R9
  lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr_i |=> lo_q == $past(lo_data_i));
  // R9
  hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr_i |=> hi_q == $past(hi_data_i));
endmodule

// File: rtl/gated_tick_counter.sv
module gated_tick_counter #(
  parameter int BYTE_W      = 8,
  parameter int NARROW_LO   = 5,
  parameter int DIV         = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_pin,
  input  logic              gate_pin,
  input  logic              run_en,
  input  logic              gate_mode,
  input  logic              src_sel,
  input  logic              wide_mode,
  input  logic              lo_wr_en,
  input  logic [BYTE_W-1:0] lo_wr_data,
  input  logic              hi_wr_en,
  input  logic [BYTE_W-1:0] hi_wr_data,
  input  logic              flag_clr,
  output logic [BYTE_W-1:0] count_lo,
  output logic [BYTE_W-1:0] count_hi,
  output logic              ovf_flag
);
  import tmr_pkg::*;

  src_e src;
  logic count_en, tick, fall, step, wrap, flag_q;

  assign src      = src_e'(src_sel);
  assign count_en = run_en & (~gate_mode | gate_pin);

  tmr_prescale #(.DIV(DIV)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (count_en && (src == SRC_TICK)),
    .tick_o (tick)
  );

  tmr_fall_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (cnt_pin),
    .fall_o (fall)
  );

  assign step = count_en & ((src == SRC_PIN) ? fall : tick);

  tmr_count_core #(.BYTE_W(BYTE_W), .NARROW_LO(NARROW_LO)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (step),
    .wide_i    (wide_mode),
    .lo_wr_i   (lo_wr_en),
    .lo_data_i (lo_wr_data),
    .hi_wr_i   (hi_wr_en),
    .hi_data_i (hi_wr_data),
    .lo_o      (count_lo),
    .hi_o      (count_hi),
    .wrap_o    (wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (wrap)     flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign ovf_flag = flag_q;

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);
  // R8
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_flag);
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !lo_wr_en && !hi_wr_en) |=> ($stable(count_lo) && $stable(count_hi)));
  // R6
  wide_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && wide_mode) |=> (count_lo == '0 && count_hi == '0));
endmodule

// File: tb/gated_tick_counter_test.sv
`timescale 1ns/1ps
module gated_tick_counter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_pin = 1'b1, gate_pin = 1'b0, run_en = 1'b0, gate_mode = 1'b0;
  logic src_sel = 1'b0, wide_mode = 1'b1, lo_wr_en = 1'b0, hi_wr_en = 1'b0, flag_clr = 1'b0;
  logic [7:0] lo_wr_data = '0, hi_wr_data = '0;
  logic [7:0] count_lo, count_hi;
  logic ovf_flag;

  int errors = 0, checks = 0;
  int acc = 0;
  logic [15:0] exp_cnt = '0;
  logic exp_flag = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gated_tick_counter uut (
    .clk(clk), .rst_n(rst_n), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .run_en(run_en), .gate_mode(gate_mode), .src_sel(src_sel), .wide_mode(wide_mode),
    .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data), .hi_wr_en(hi_wr_en),
    .hi_wr_data(hi_wr_data), .flag_clr(flag_clr),
    .count_lo(count_lo), .count_hi(count_hi), .ovf_flag(ovf_flag)
  );

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check(req, {ovf_flag, count_hi, count_lo}, {exp_flag, exp_cnt});
  endtask

  task automatic bump(input int n);
    for (int i = 0; i < n; i++) begin
      if (wide_mode) begin
        if (exp_cnt == 16'hFFFF) exp_flag = 1'b1;
        exp_cnt = exp_cnt + 16'd1;
      end else begin
        logic [12:0] nv;
        nv = {exp_cnt[15:8], exp_cnt[4:0]} + 13'd1;
        if (nv == 13'd0) exp_flag = 1'b1;
        exp_cnt = {nv[12:5], exp_cnt[7:5], nv[4:0]};
      end
    end
  endtask

  task automatic load(input logic [15:0] v);
    @(negedge clk);
    lo_wr_en = 1'b1; hi_wr_en = 1'b1; lo_wr_data = v[7:0]; hi_wr_data = v[15:8];
    @(negedge clk);
    lo_wr_en = 1'b0; hi_wr_en = 1'b0;
    exp_cnt = v;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    exp_flag = 1'b0;
  endtask

  task automatic timer_run(input int k);
    @(negedge clk); src_sel = 1'b0; run_en = 1'b1;
    repeat (k) @(negedge clk);
    run_en = 1'b0;
    bump((acc + k) / 12 - acc / 12);
    acc += k;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_pin = 1'b0;
      @(negedge clk); cnt_pin = 1'b1;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_state("R1");

    // R2 first tick on the 12th enabled cycle
    @(negedge clk); src_sel = 1'b0; wide_mode = 1'b1; run_en = 1'b1;
    repeat (11) @(negedge clk);
    check_state("R2");
    @(negedge clk);
    exp_cnt = 16'd1;
    check_state("R2");
    run_en = 1'b0; acc = 12;

    // R2 odd run lengths, prescaler phase held between runs
    timer_run(7);  check_state("R2");
    timer_run(7);  check_state("R2");
    timer_run(29); check_state("R2");

    // R9 write replaces bytes, write cycles suppress steps
    load(16'h10FE); check_state("R9");
    @(negedge clk); src_sel = 1'b0; run_en = 1'b1; hi_wr_en = 1'b1; hi_wr_data = 8'h10;
    repeat (36) @(negedge clk);
    hi_wr_en = 1'b0; run_en = 1'b0; acc += 36;
    check_state("R9");
    @(negedge clk); run_en = 1'b1; lo_wr_en = 1'b1; lo_wr_data = 8'h55;
    repeat (24) @(negedge clk);
    lo_wr_en = 1'b0; run_en = 1'b0; acc += 24;
    exp_cnt = 16'h1055;
    check_state("R9");

    // R3 latency of a falling edge in pin mode
    load(16'h0200);
    @(negedge clk); src_sel = 1'b1; run_en = 1'b1;
    @(negedge clk); cnt_pin = 1'b0;
    @(negedge clk); check_state("R3");
    @(negedge clk); check_state("R3");
    @(negedge clk); bump(1); check_state("R3");
    cnt_pin = 1'b1;
    repeat (3) @(negedge clk);
    // R4 maximum rate
    pulses(10); bump(10); check_state("R4");
    run_en = 1'b0;

    // R6 wide wraps from several starts
    for (int s = 0; s < 4; s++) begin
      logic [15:0] st;
      st = (s == 0) ? 16'hFFFE : (s == 1) ? 16'h00FF : (s == 2) ? 16'hFFFF : 16'h7FFF;
      load(st);
      wide_mode = 1'b1;
      timer_run(36);
      check_state("R6");
      clear_flag();
      check_state("R8");
    end

    // R7 narrow wrap with every pattern in the untouched low-byte bits
    for (int u = 0; u < 8; u++) begin
      load({8'hFF, 3'(u), 5'h1E});
      @(negedge clk); wide_mode = 1'b0; src_sel = 1'b1; run_en = 1'b1;
      pulses(2); bump(2);
      run_en = 1'b0;
      check_state("R7");
      // R8 flag stays set with no clear
      repeat (5) @(negedge clk);
      check_state("R8");
      clear_flag();
    end

    // R8 clear in the same cycle as a wrap leaves the flag set
    load(16'hFFFF);
    @(negedge clk); wide_mode = 1'b1; src_sel = 1'b1; run_en = 1'b1;
    @(negedge clk); cnt_pin = 1'b0;
    @(negedge clk);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0; cnt_pin = 1'b1; bump(1);
    check_state("R8");
    run_en = 1'b0;
    clear_flag();
    check_state("R8");

    // R5 sweep of run, gate mode, gate pin, source and width
    for (int c = 0; c < 32; c++) begin
      logic en;
      load(16'h1234);
      @(negedge clk);
      wide_mode = c[0]; src_sel = c[1]; gate_mode = c[2]; gate_pin = c[3]; run_en = c[4];
      en = c[4] & (~c[2] | c[3]);
      if (c[1]) pulses(4);
      else repeat (24) @(negedge clk);
      run_en = 1'b0;
      if (en) begin
        bump(c[1] ? 4 : 2);
        if (!c[1]) acc += 24;
      end
      @(negedge clk);
      check_state("R5");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule